// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a virtual address to a physical address through a small table of segment slots. The upper bits of the virtual address choose a slot, and the remaining bits form an offset inside that segment. Each slot holds a physical base, a size limit, a direction flag, three access-permission bits and an enable bit. A slot with its direction flag set grows toward higher addresses. A slot with the flag clear grows toward lower addresses, as a stack does. Every request carries an access kind. The block returns either a physical address or a two-bit fault code.

System software loads a slot through the configuration port in a single cycle, so every field of the slot changes together. The same software reads the slot back through a separate readback port when it saves state on a context switch. Translation is registered: a request accepted on one clock edge produces its response on the next edge. Both sides use valid/ready handshakes, and a stalled response is held until the consumer accepts it.

Top module: `segxl_top`

## Requirements
- R1: The top SEG_W bits of `req_va` select the slot. When the selected slot is disabled, the response carries fault code 3 (no segment).
- R2: For an enabled slot that grows upward, the physical address is the slot base plus the offset (the low VA_W-SEG_W bits), taken modulo 2^PA_W. The fault code is 0.
- R3: For an upward slot, an offset greater than or equal to the slot bound gives fault code 1 (out of bounds).
- R4: For a downward slot, the magnitude is 2^(VA_W-SEG_W) minus the offset. The physical address is the base minus that magnitude. A magnitude greater than the bound gives fault code 1, and a magnitude equal to the bound is allowed.
- R5: The access kind is encoded as 0 = read, 1 = write, 2 = fetch and 3 = reserved. A read needs permission bit 0, a write needs bit 1 and a fetch needs bit 2. A kind without its permission bit, or the reserved kind, gives fault code 2.
- R6: Fault priority is: no segment, then out of bounds, then protection. Whenever the fault code is nonzero, `rsp_pa` is 0.
- R7: A request accepted at one clock edge appears on `rsp_valid` after that edge. `req_ready` is high exactly when the output stage is empty or is being accepted. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady.
- R8: A configuration write replaces every field of a slot in one edge, and the readback port shows the new values after that edge. A request accepted at the same edge as the write is translated with the old values.
- R9: After reset, no response is pending, all slots are disabled and every readback field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one slot |
| cfg_sel | input | SEG_W | Slot to write |
| cfg_base | input | PA_W | New physical base |
| cfg_bound | input | VA_W-SEG_W+1 | New size limit |
| cfg_grow_up | input | 1 | 1 = grows upward, 0 = grows downward |
| cfg_perm | input | 3 | Permissions {fetch, write, read} |
| cfg_enable | input | 1 | Slot enable |
| rb_sel | input | SEG_W | Slot to read back |
| rb_base | output | PA_W | Readback base |
| rb_bound | output | VA_W-SEG_W+1 | Readback bound |
| rb_grow_up | output | 1 | Readback direction |
| rb_perm | output | 3 | Readback permissions |
| rb_enable | output | 1 | Readback enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_va | input | VA_W | Virtual address |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1 bound, 2 protection, 3 no segment |

## Verification
Three segments are programmed: an upward code segment that can be read and fetched, an upward read-write heap, and a downward read-write stack. A fourth slot is left disabled. Addresses are chosen at and one step past each limit, so the bench can tell an off-by-one in the compare (at or past the bound) from a reversed subtraction in the downward case. Each segment also receives every access kind, and some addresses violate both bound and permission, which exposes any error in fault priority. Directed sequences cover output back-pressure and a configuration write in the same cycle as a request, which separates a registered table from one that passes new values straight through.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_OK    = 2'd0,
    FLT_BOUND = 2'd1,
    FLT_PROT  = 2'd2,
    FLT_NOSEG = 2'd3
  } flt_e;

  localparam int PERM_W = 3;

  // Permission vector bits: [0] read, [1] write, [2] fetch.
  function automatic logic perm_allows(logic [PERM_W-1:0] perm, logic [1:0] kind);
    case (kind)
      ACC_READ:  return perm[0];
      ACC_WRITE: return perm[1];
      ACC_FETCH: return perm[2];
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/segxl_table.sv
module segxl_table #(
  parameter int NSEG  = 4,
  parameter int SEG_W = 2,
  parameter int PA_W  = 16,
  parameter int BND_W = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [SEG_W-1:0]              wsel,
  input  logic [PA_W-1:0]               wbase,
  input  logic [BND_W-1:0]              wbound,
  input  logic                          wup,
  input  logic [segxl_pkg::PERM_W-1:0]  wperm,
  input  logic                          wen,
  input  logic [SEG_W-1:0]              lsel,
  output logic [PA_W-1:0]               l_base,
  output logic [BND_W-1:0]              l_bound,
  output logic                          l_up,
  output logic [segxl_pkg::PERM_W-1:0]  l_perm,
  output logic                          l_en,
  input  logic [SEG_W-1:0]              rsel,
  output logic [PA_W-1:0]               r_base,
  output logic [BND_W-1:0]              r_bound,
  output logic                          r_up,
  output logic [segxl_pkg::PERM_W-1:0]  r_perm,
  output logic                          r_en
);
  logic [PA_W-1:0]              base_q  [NSEG];
  logic [BND_W-1:0]             bound_q [NSEG];
  logic                         up_q    [NSEG];
  logic [segxl_pkg::PERM_W-1:0] perm_q  [NSEG];
  logic                         en_q    [NSEG];

  // All fields of a slot change together at one edge.
  for (genvar g = 0; g < NSEG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        bound_q[g] <= '0;
        up_q[g]    <= 1'b0;
        perm_q[g]  <= '0;
        en_q[g]    <= 1'b0;
      end else if (we && (wsel == SEG_W'(g))) begin
        base_q[g]  <= wbase;
        bound_q[g] <= wbound;
        up_q[g]    <= wup;
        perm_q[g]  <= wperm;
        en_q[g]    <= wen;
      end
    end
  end

  always_comb begin
    l_base  = base_q[lsel];
    l_bound = bound_q[lsel];
    l_up    = up_q[lsel];
    l_perm  = perm_q[lsel];
    l_en    = en_q[lsel];
    r_base  = base_q[rsel];
    r_bound = bound_q[rsel];
    r_up    = up_q[rsel];
    r_perm  = perm_q[rsel];
    r_en    = en_q[rsel];
  end
endmodule

// File: rtl/segxl_xlate.sv
module segxl_xlate #(
  parameter int OFF_W = 12,
  parameter int PA_W  = 16,
  parameter int BND_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0]              off,
  input  logic [1:0]                    kind,
  input  logic [PA_W-1:0]               base,
  input  logic [BND_W-1:0]              bound,
  input  logic                          up,
  input  logic [segxl_pkg::PERM_W-1:0]  perm,
  input  logic                          en,
  output logic [PA_W-1:0]               pa,
  output logic [1:0]                    fault,
  output logic                          hit_noseg,
  output logic                          hit_bound,
  output logic                          hit_prot
);
  import segxl_pkg::*;

  // Distance below the base for a downward segment: 2^OFF_W - off.
  function automatic logic [BND_W-1:0] down_mag(logic [OFF_W-1:0] o);
    return {1'b1, {OFF_W{1'b0}}} - {1'b0, o};
  endfunction

  function automatic logic beyond(logic d, logic [OFF_W-1:0] o, logic [BND_W-1:0] b);
    if (d) return ({1'b0, o} >= b);
    return (down_mag(o) > b);
  endfunction

  function automatic logic [PA_W-1:0] phys(logic d, logic [PA_W-1:0] bs, logic [OFF_W-1:0] o);
    if (d) return bs + PA_W'(o);
    return bs - PA_W'(down_mag(o));
  endfunction

  always_comb begin
    hit_noseg = !en;
    hit_bound = en && beyond(up, off, bound);
    hit_prot  = en && !beyond(up, off, bound) && !perm_allows(perm, kind);
    if (hit_noseg)      fault = FLT_NOSEG;
    else if (hit_bound) fault = FLT_BOUND;
    else if (hit_prot)  fault = FLT_PROT;
    else                fault = FLT_OK;
    pa = (fault == FLT_OK) ? phys(up, base, off) : '0;
  end
endmodule

// File: rtl/segxl_top.sv
module segxl_top #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 16,
  parameter int SEG_W = 2,
  localparam int OFF_W = VA_W - SEG_W,
  localparam int BND_W = OFF_W + 1,
  localparam int NSEG  = 1 << SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_sel,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [BND_W-1:0]  cfg_bound,
  input  logic              cfg_grow_up,
  input  logic [2:0]        cfg_perm,
  input  logic              cfg_enable,
  input  logic [SEG_W-1:0]  rb_sel,
  output logic [PA_W-1:0]   rb_base,
  output logic [BND_W-1:0]  rb_bound,
  output logic              rb_grow_up,
  output logic [2:0]        rb_perm,
  output logic              rb_enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_fault
);
  logic [SEG_W-1:0] seg_idx;
  logic [OFF_W-1:0] seg_off;
  logic [PA_W-1:0]  e_base;
  logic [BND_W-1:0] e_bound;
  logic             e_up;
  logic [2:0]       e_perm;
  logic             e_en;
  logic [PA_W-1:0]  x_pa;
  logic [1:0]       x_fault;
  logic             x_noseg, x_bound, x_prot;
  logic             accept;

  assign seg_idx = req_va[VA_W-1 -: SEG_W];
  assign seg_off = req_va[OFF_W-1:0];

  segxl_table #(.NSEG(NSEG), .SEG_W(SEG_W), .PA_W(PA_W), .BND_W(BND_W)) i_table (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we), .wsel(cfg_sel), .wbase(cfg_base), .wbound(cfg_bound),
    .wup(cfg_grow_up), .wperm(cfg_perm), .wen(cfg_enable),
    .lsel(seg_idx), .l_base(e_base), .l_bound(e_bound), .l_up(e_up),
    .l_perm(e_perm), .l_en(e_en),
    .rsel(rb_sel), .r_base(rb_base), .r_bound(rb_bound), .r_up(rb_grow_up),
    .r_perm(rb_perm), .r_en(rb_enable)
  );

  segxl_xlate #(.OFF_W(OFF_W), .PA_W(PA_W), .BND_W(BND_W)) i_xlate (
    .off(seg_off), .kind(req_kind), .base(e_base), .bound(e_bound),
    .up(e_up), .perm(e_perm), .en(e_en),
    .pa(x_pa), .fault(x_fault),
    .hit_noseg(x_noseg), .hit_bound(x_bound), .hit_prot(x_prot)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_pa    <= x_pa;
      rsp_fault <= x_fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/segxl_chk.sv
module segxl_chk #(
  parameter int PA_W  = 16,
  parameter int SEG_W = 2,
  parameter int BND_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_pa,
  input logic [1:0]       rsp_fault,
  input logic             cfg_we,
  input logic [SEG_W-1:0] cfg_sel,
  input logic [PA_W-1:0]  cfg_base,
  input logic [BND_W-1:0] cfg_bound,
  input logic [SEG_W-1:0] rb_sel,
  input logic [PA_W-1:0]  rb_base,
  input logic [BND_W-1:0] rb_bound,
  input logic             hit_noseg,
  input logic             hit_bound,
  input logic             hit_prot
);
  assert_fault_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_noseg, hit_bound, hit_prot}));

  assert_fault_zero_pa_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_pa == '0));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)));

  assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && rb_sel == cfg_sel) |=>
      ($stable(rb_sel) |-> (rb_base == $past(cfg_base) && rb_bound == $past(cfg_bound))));
endmodule

bind segxl_top segxl_chk #(.PA_W(PA_W), .SEG_W(SEG_W), .BND_W(BND_W)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_bound(cfg_bound),
  .rb_sel(rb_sel), .rb_base(rb_base), .rb_bound(rb_bound),
  .hit_noseg(x_noseg), .hit_bound(x_bound), .hit_prot(x_prot)
);

// File: tb/test_segxl_top.sv
module test_segxl_top;
  localparam int VA_W = 14, PA_W = 16, SEG_W = 2, BND_W = 13;
  localparam int NV = 14;
  // Entry: {va, kind, expected pa, expected fault}
  localparam logic [33:0] VEC [NV] = '{
    {14'h0010, 2'd2, 16'h1010, 2'd0},  // R2 fetch from code
    {14'h07FF, 2'd0, 16'h17FF, 2'd0},  // R3 last offset inside
    {14'h0800, 2'd0, 16'h0000, 2'd1},  // R3 offset equal to bound
    {14'h0010, 2'd1, 16'h0000, 2'd2},  // R5 write to read-only
    {14'h1123, 2'd1, 16'h4123, 2'd0},  // R2 heap write
    {14'h1123, 2'd2, 16'h0000, 2'd2},  // R5 fetch from heap
    {14'h2005, 2'd0, 16'h0000, 2'd3},  // R1 disabled slot
    {14'h3F00, 2'd0, 16'h7F00, 2'd0},  // R4 stack read
    {14'h3E00, 2'd1, 16'h7E00, 2'd0},  // R4 magnitude equal bound
    {14'h3DFF, 2'd0, 16'h0000, 2'd1},  // R4 one past
    {14'h3000, 2'd0, 16'h0000, 2'd1},  // R4 offset zero, full size
    {14'h1400, 2'd0, 16'h0000, 2'd1},  // R3 heap limit
    {14'h1010, 2'd3, 16'h0000, 2'd2},  // R5 reserved kind
    {14'h0800, 2'd1, 16'h0000, 2'd1}   // R6 bound beats protection
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_grow_up = 1'b0, cfg_enable = 1'b0;
  logic [SEG_W-1:0] cfg_sel = '0, rb_sel = '0;
  logic [PA_W-1:0] cfg_base = '0;
  logic [BND_W-1:0] cfg_bound = '0;
  logic [2:0] cfg_perm = '0;
  logic [PA_W-1:0] rb_base;
  logic [BND_W-1:0] rb_bound;
  logic rb_grow_up, rb_enable;
  logic [2:0] rb_perm;
  logic req_valid = 1'b0, req_ready, rsp_valid, rsp_ready = 1'b1;
  logic [VA_W-1:0] req_va = '0;
  logic [1:0] req_kind = '0, rsp_fault;
  logic [PA_W-1:0] rsp_pa;
  int nchk = 0, nbad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  segxl_top i_segxl_top (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic program_slot(int s, logic [15:0] b, logic [12:0] bd, logic up, logic [2:0] p, logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = SEG_W'(s); cfg_base = b; cfg_bound = bd;
    cfg_grow_up = up; cfg_perm = p; cfg_enable = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic one_req(logic [13:0] va, logic [1:0] k);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_kind = k; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check("R9 rsp_valid", 32'(rsp_valid), 0);
    check("R9 req_ready", 32'(req_ready), 1);
    rb_sel = 2'd3;
    #1 check("R9 readback", {rb_base, 3'(rb_bound >> 10), rb_perm, rb_grow_up, rb_enable}, 0);

    program_slot(0, 16'h1000, 13'h0800, 1'b1, 3'b101, 1'b1);
    program_slot(1, 16'h4000, 13'h0400, 1'b1, 3'b011, 1'b1);
    program_slot(3, 16'h8000, 13'h0200, 1'b0, 3'b011, 1'b1);
    rb_sel = 2'd1;
    #1 check("R8 readback", {rb_base, 3'b0, rb_bound}, {16'h4000, 3'b0, 13'h0400});
    check("R8 readback flags", {rb_perm, rb_grow_up, rb_enable}, {3'b011, 2'b11});

    for (int i = 0; i < NV; i++) begin
      one_req(VEC[i][33:20], VEC[i][19:18]);
      check($sformatf("R1-6 vec%0d valid R7", i), 32'(rsp_valid), 1);
      check($sformatf("vec%0d pa", i), 32'(rsp_pa), 32'(VEC[i][17:2]));
      check($sformatf("vec%0d fault", i), 32'(rsp_fault), 32'(VEC[i][1:0]));
    end
    @(negedge clk);
    check("R7 drained", 32'(rsp_valid), 0);

    // R7 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_va = 14'h0020; req_kind = 2'd0;
    @(negedge clk);
    req_va = 14'h1030;
    check("R7 ready low when stalled", 32'(req_ready), 0);
    @(negedge clk);
    check("R7 hold pa", 32'(rsp_pa), 32'h1020);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 next pa", 32'(rsp_pa), 32'h4030);

    // R8 write and request at the same edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_base = 16'h5000; cfg_bound = 13'h0400;
    cfg_grow_up = 1'b1; cfg_perm = 3'b011; cfg_enable = 1'b1;
    req_valid = 1'b1; req_va = 14'h1001; req_kind = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R8 old values used", 32'(rsp_pa), 32'h4001);
    one_req(14'h1001, 2'd0);
    check("R8 new values used", 32'(rsp_pa), 32'h5001);

    // R1 disabling a slot
    program_slot(0, 16'h1000, 13'h0800, 1'b1, 3'b101, 1'b0);
    one_req(14'h0010, 2'd0);
    check("R1 disabled", 32'(rsp_fault), 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule